// File: doc/BRIEF.md
# Reorder Buffer with Incremental Squash

This block keeps dispatched instructions in program order for an out-of-order core. It is a circular buffer. Each new instruction is written at the allocation slot together with its sequence number, PC and next PC. Execution units report completion through a writeback port that names the slot index. The oldest entry leaves the buffer once it has completed and the retire strobe is given. The fields of the oldest entry and of the youngest entry can be read in every cycle, together with a free-slot count and full and empty flags.

A squash request carries a sequence number and removes every entry younger than it. The entry that holds that sequence number stays. The removal is not a single-cycle flush. A walk controller with two named states, SQ_IDLE and SQ_WALK, steps from the youngest entry toward the oldest and marks at most SQUASH_WIDTH entries per cycle. It has three transitions:
- START: SQ_IDLE to SQ_WALK, taken on a request.
- STEP: SQ_WALK stays in SQ_WALK while every entry examined in the cycle was marked.
- FINISH: SQ_WALK to SQ_IDLE, taken when the walk reaches a surviving entry or runs out of entries.

While SQ_WALK is active, the youngest-entry pointer and the occupancy are frozen, and inserts and retires are refused. On FINISH, the allocation pointer is pulled back to just after the survivor and the occupancy drops in the same cycle. Sequence numbers are compared as unsigned values, so a larger number is younger.

Top module: `rob_walk_top`

## Requirements
- R1: After reset, the buffer is empty: `empty`=1, `full`=0, `free_cnt`=NUM_ENTRIES, `sq_done`=1 and `alloc_idx`=0.
- R2: An insert (`ins_en`=1) taken in SQ_IDLE writes slot `alloc_idx` and raises the occupancy by one. The `tail_*` outputs show the youngest entry and the `head_*` outputs show the oldest. `full` is 1 exactly when the occupancy equals NUM_ENTRIES, and `empty` is 1 exactly when it is 0. An insert while full is ignored.
- R3: A writeback (`wb_en`=1) marks slot `wb_idx` complete. `head_rdy` is 1 exactly when the buffer is non-empty and the oldest entry is complete and not marked squashed.
- R4: A retire (`ret_en`=1) while `head_rdy`=1 in SQ_IDLE removes the oldest entry. A retire while `head_rdy`=0 is ignored.
- R5: An insert and a retire in the same cycle leave the occupancy unchanged. Both pointers wrap from NUM_ENTRIES-1 to 0.
- R6: A request (`sq_en`=1) taken in SQ_IDLE drops `sq_done` after that clock edge. When m entries are younger than the target, `sq_done` stays 0 for floor(m/SQUASH_WIDTH)+1 further clock edges and then returns to 1. No more than SQUASH_WIDTH entries are marked in any cycle.
- R7: While `sq_done`=0, `alloc_idx`, the `tail_*` outputs and `free_cnt` keep their values.
- R8: Inserts and retires are ignored while `sq_done`=0 and in the cycle in which a request is taken.
- R9: A request during a walk that names an older sequence number than the current target retargets the walk to it. A request naming an equal or younger sequence number is ignored.
- R10: At FINISH, the entry whose sequence number equals the target is kept and becomes the youngest entry. If no entry is at or below the target, the buffer becomes empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_en | input | 1 | Insert strobe |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_pc | input | PC_W | PC of the inserted instruction |
| ins_npc | input | PC_W | Next PC of the inserted instruction |
| wb_en | input | 1 | Completion writeback strobe |
| wb_idx | input | IDX_W | Slot index being marked complete |
| ret_en | input | 1 | Retire strobe for the oldest entry |
| sq_en | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Sequence number of the squash target (kept) |
| alloc_idx | output | IDX_W | Slot that the next insert will occupy |
| head_seq | output | SEQ_W | Oldest entry sequence number (undefined when empty) |
| head_pc | output | PC_W | Oldest entry PC |
| head_npc | output | PC_W | Oldest entry next PC |
| head_rdy | output | 1 | Oldest entry may retire |
| tail_seq | output | SEQ_W | Youngest entry sequence number (undefined when empty) |
| tail_pc | output | PC_W | Youngest entry PC |
| free_cnt | output | CNT_W | Number of free slots |
| full | output | 1 | Occupancy equals NUM_ENTRIES |
| empty | output | 1 | Occupancy is zero |
| sq_done | output | 1 | High when no squash walk is in progress |

## Verification
Two pairs of functions can fall in the same cycle: an insert with a retire, and a squash request with an insert or retire. The bench drives an insert together with a retire of a completed head while the buffer is partly full, and expects the free count to stay put while both pointers advance and wrap. It raises insert and retire together with a squash request, and again in the first walk cycle. A behavioural queue model compares head, tail, counts, ready and done on every clock, and judges that nothing was added or removed and that the walk length follows floor(m/SQUASH_WIDTH)+1.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_WALK = 1'b1
    } sq_state_e;
endpackage

// File: rtl/rob_store.sv
module rob_store #(
    parameter int NUM_ENTRIES = 8,
    parameter int SEQ_W       = 16,
    parameter int PC_W        = 32,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [SEQ_W-1:0]                  wr_seq,
    input  logic [PC_W-1:0]                   wr_pc,
    input  logic [PC_W-1:0]                   wr_npc,
    input  logic                              wb_en,
    input  logic [IDX_W-1:0]                  wb_idx,
    input  logic [NUM_ENTRIES-1:0]            sq_mask,
    input  logic [IDX_W-1:0]                  head_idx,
    input  logic [IDX_W-1:0]                  last_idx,
    output logic [NUM_ENTRIES-1:0][SEQ_W-1:0] seq_all,
    output logic [SEQ_W-1:0]                  head_seq,
    output logic [PC_W-1:0]                   head_pc,
    output logic [PC_W-1:0]                   head_npc,
    output logic                              head_cmp,
    output logic                              head_sqd,
    output logic [SEQ_W-1:0]                  tail_seq,
    output logic [PC_W-1:0]                   tail_pc
);
    logic [NUM_ENTRIES-1:0][SEQ_W-1:0] seq_q;
    logic [NUM_ENTRIES-1:0][PC_W-1:0]  pc_q;
    logic [NUM_ENTRIES-1:0][PC_W-1:0]  npc_q;
    logic [NUM_ENTRIES-1:0]            cmp_q;
    logic [NUM_ENTRIES-1:0]            sqd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            seq_q[wr_idx] <= wr_seq;
            pc_q[wr_idx]  <= wr_pc;
            npc_q[wr_idx] <= wr_npc;
        end
    end

    // insert clears the flags; writeback and squash marks set them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            sqd_q <= '0;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (wr_en && wr_idx == IDX_W'(i)) begin
                    cmp_q[i] <= 1'b0;
                    sqd_q[i] <= 1'b0;
                end else begin
                    if (wb_en && wb_idx == IDX_W'(i)) cmp_q[i] <= 1'b1;
                    if (sq_mask[i])                   sqd_q[i] <= 1'b1;
                end
            end
        end
    end

    assign seq_all  = seq_q;
    assign head_seq = seq_q[head_idx];
    assign head_pc  = pc_q[head_idx];
    assign head_npc = npc_q[head_idx];
    assign head_cmp = cmp_q[head_idx];
    assign head_sqd = sqd_q[head_idx];
    assign tail_seq = seq_q[last_idx];
    assign tail_pc  = pc_q[last_idx];

    // R3
    ins_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!cmp_q[$past(wr_idx)] && !sqd_q[$past(wr_idx)]));
endmodule

// File: rtl/rob_squash_walk.sv
module rob_squash_walk #(
    parameter int NUM_ENTRIES  = 8,
    parameter int SQUASH_WIDTH = 2,
    parameter int SEQ_W        = 16,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sq_en,
    input  logic [SEQ_W-1:0]                  sq_seq,
    input  logic [CNT_W-1:0]                  cnt,
    input  logic [IDX_W-1:0]                  head_idx,
    input  logic [NUM_ENTRIES-1:0][SEQ_W-1:0] seq_all,
    output logic [NUM_ENTRIES-1:0]            mark,
    output logic                              fin,
    output logic [CNT_W-1:0]                  keep_n,
    output logic                              done
);
    import rob_pkg::*;

    sq_state_e              state_q;
    logic [SEQ_W-1:0]       tgt_q;
    logic [CNT_W-1:0]       walk_q;
    logic [SEQ_W-1:0]       eff_tgt;
    logic [CNT_W-1:0]       cur_n;
    logic                   stop;
    logic [NUM_ENTRIES-1:0] mark_raw;
    int                     slot;

    assign eff_tgt = (state_q == SQ_WALK && sq_en && sq_seq < tgt_q) ? sq_seq : tgt_q;

    // backward step over up to SQUASH_WIDTH entries starting at the youngest unexamined
    always_comb begin
        mark_raw = '0;
        stop     = 1'b0;
        cur_n    = walk_q;
        slot     = 0;
        for (int k = 0; k < SQUASH_WIDTH; k++) begin
            if (!stop) begin
                if (cur_n == '0) begin
                    stop = 1'b1;
                end else begin
                    slot = int'(head_idx) + int'(cur_n) - 1;
                    if (slot >= NUM_ENTRIES) slot = slot - NUM_ENTRIES;
                    if (seq_all[slot[IDX_W-1:0]] > eff_tgt) begin
                        mark_raw[slot[IDX_W-1:0]] = 1'b1;
                        cur_n = cur_n - CNT_W'(1);
                    end else begin
                        stop = 1'b1;
                    end
                end
            end
        end
    end

    // state register: START, STEP, FINISH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            tgt_q   <= '0;
            walk_q  <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (sq_en) begin
                        state_q <= SQ_WALK;
                        tgt_q   <= sq_seq;
                        walk_q  <= cnt;
                    end
                end
                SQ_WALK: begin
                    tgt_q  <= eff_tgt;
                    walk_q <= cur_n;
                    if (stop) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        done   = (state_q == SQ_IDLE);
        fin    = (state_q == SQ_WALK) && stop;
        mark   = (state_q == SQ_WALK) ? mark_raw : '0;
        keep_n = cur_n;
    end

    // R6
    walk_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mark) <= SQUASH_WIDTH);
    // R6
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE && sq_en) |=> !done);
    // R9
    walk_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WALK) |=> walk_q <= $past(walk_q));
endmodule

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_do,
    input  logic             ret_do,
    input  logic             walking,
    input  logic             reclaim,
    input  logic [CNT_W-1:0] keep_n,
    output logic [IDX_W-1:0] head_q,
    output logic [IDX_W-1:0] tail_q,
    output logic [CNT_W-1:0] cnt_q
);
    logic [IDX_W-1:0] back_tail;
    int               sum;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(NUM_ENTRIES - 1)) ? '0 : p + IDX_W'(1);
    endfunction

    always_comb begin
        sum = int'(head_q) + int'(keep_n);
        if (sum >= NUM_ENTRIES) sum = sum - NUM_ENTRIES;
        back_tail = sum[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else if (reclaim) begin
            tail_q <= back_tail;
            cnt_q  <= keep_n;
        end else begin
            if (ins_do) tail_q <= bump(tail_q);
            if (ret_do) head_q <= bump(head_q);
            cnt_q <= cnt_q + CNT_W'(ins_do) - CNT_W'(ret_do);
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(NUM_ENTRIES));
    // R4
    ret_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_do |-> cnt_q != '0);
    // R7
    tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walking && !reclaim) |=> (tail_q == $past(tail_q) && cnt_q == $past(cnt_q)));
endmodule

// File: rtl/rob_walk_top.sv
module rob_walk_top #(
    parameter int NUM_ENTRIES  = 8,
    parameter int SQUASH_WIDTH = 2,
    parameter int SEQ_W        = 16,
    parameter int PC_W         = 32,
    localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
    localparam int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic [PC_W-1:0]  ins_npc,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic             ret_en,
    input  logic             sq_en,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic [IDX_W-1:0] alloc_idx,
    output logic [SEQ_W-1:0] head_seq,
    output logic [PC_W-1:0]  head_pc,
    output logic [PC_W-1:0]  head_npc,
    output logic             head_rdy,
    output logic [SEQ_W-1:0] tail_seq,
    output logic [PC_W-1:0]  tail_pc,
    output logic [CNT_W-1:0] free_cnt,
    output logic             full,
    output logic             empty,
    output logic             sq_done
);
    logic [IDX_W-1:0]                  head_q, tail_q, last_idx;
    logic [CNT_W-1:0]                  cnt_q, keep_n;
    logic [NUM_ENTRIES-1:0]            mark;
    logic [NUM_ENTRIES-1:0][SEQ_W-1:0] seq_all;
    logic                              fin, head_cmp, head_sqd, ins_do, ret_do;

    assign full     = (cnt_q == CNT_W'(NUM_ENTRIES));
    assign empty    = (cnt_q == '0);
    assign free_cnt = CNT_W'(NUM_ENTRIES) - cnt_q;
    assign last_idx = (tail_q == '0) ? IDX_W'(NUM_ENTRIES - 1) : tail_q - IDX_W'(1);
    assign head_rdy = !empty && head_cmp && !head_sqd;
    assign ins_do   = ins_en && !full && sq_done && !sq_en;
    assign ret_do   = ret_en && head_rdy && sq_done && !sq_en;
    assign alloc_idx = tail_q;

    rob_ptrs #(.NUM_ENTRIES(NUM_ENTRIES)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .ins_do(ins_do), .ret_do(ret_do),
        .walking(!sq_done), .reclaim(fin), .keep_n(keep_n),
        .head_q(head_q), .tail_q(tail_q), .cnt_q(cnt_q)
    );

    rob_squash_walk #(.NUM_ENTRIES(NUM_ENTRIES), .SQUASH_WIDTH(SQUASH_WIDTH),
                      .SEQ_W(SEQ_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .sq_en(sq_en), .sq_seq(sq_seq), .cnt(cnt_q),
        .head_idx(head_q), .seq_all(seq_all), .mark(mark), .fin(fin),
        .keep_n(keep_n), .done(sq_done)
    );

    rob_store #(.NUM_ENTRIES(NUM_ENTRIES), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(ins_do), .wr_idx(tail_q), .wr_seq(ins_seq),
        .wr_pc(ins_pc), .wr_npc(ins_npc), .wb_en(wb_en), .wb_idx(wb_idx),
        .sq_mask(mark), .head_idx(head_q), .last_idx(last_idx), .seq_all(seq_all),
        .head_seq(head_seq), .head_pc(head_pc), .head_npc(head_npc),
        .head_cmp(head_cmp), .head_sqd(head_sqd), .tail_seq(tail_seq), .tail_pc(tail_pc)
    );

    // R8
    walk_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_done |=> (head_q == $past(head_q)));
endmodule

// File: tb/rob_walk_top_test.sv
`timescale 1ns/1ps
module rob_walk_top_test;
    localparam int N = 8, SW = 2, SEQ_W = 16, PC_W = 32, IDX_W = 3, CNT_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ins_en = 0, wb_en = 0, ret_en = 0, sq_en = 0;
    logic [SEQ_W-1:0] ins_seq = '0, sq_seq = '0;
    logic [PC_W-1:0]  ins_pc = '0, ins_npc = '0;
    logic [IDX_W-1:0] wb_idx = '0;
    logic [IDX_W-1:0] alloc_idx;
    logic [SEQ_W-1:0] head_seq, tail_seq;
    logic [PC_W-1:0]  head_pc, head_npc, tail_pc;
    logic             head_rdy, full, empty, sq_done;
    logic [CNT_W-1:0] free_cnt;

    always #10 clk = ~clk;

    rob_walk_top #(.NUM_ENTRIES(N), .SQUASH_WIDTH(SW), .SEQ_W(SEQ_W), .PC_W(PC_W)) uut (
        .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_seq(ins_seq), .ins_pc(ins_pc),
        .ins_npc(ins_npc), .wb_en(wb_en), .wb_idx(wb_idx), .ret_en(ret_en),
        .sq_en(sq_en), .sq_seq(sq_seq), .alloc_idx(alloc_idx), .head_seq(head_seq),
        .head_pc(head_pc), .head_npc(head_npc), .head_rdy(head_rdy),
        .tail_seq(tail_seq), .tail_pc(tail_pc), .free_cnt(free_cnt), .full(full),
        .empty(empty), .sq_done(sq_done)
    );

    int checks = 0, fails = 0, cycles = 0, lowc = 0;
    bit finished = 0;
    int mseq[$];
    bit mcmp[$];
    int mhead = 0, mwn = 0, mtgt = 0;
    bit mwalk = 0;

    function automatic int pcof(int s); return 32'h1000 + s * 4; endfunction

    task automatic chk(string r, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic model_step();
        int sz = mseq.size();
        if (wb_en) begin
            int p = (int'(wb_idx) - mhead + N) % N;
            if (p < sz) mcmp[p] = 1'b1;
        end
        if (!mwalk) begin
            if (sq_en) begin
                mwalk = 1'b1; mwn = sz; mtgt = int'(sq_seq);
            end else begin
                bit rdy = (sz > 0) && mcmp[0];
                if (ins_en && sz < N) begin mseq.push_back(int'(ins_seq)); mcmp.push_back(1'b0); end
                if (ret_en && rdy) begin
                    void'(mseq.pop_front()); void'(mcmp.pop_front()); mhead = (mhead + 1) % N;
                end
            end
        end else begin
            int eff = (sq_en && int'(sq_seq) < mtgt) ? int'(sq_seq) : mtgt;
            bit stop = 1'b0;
            for (int k = 0; k < SW; k++) begin
                if (!stop) begin
                    if (mwn == 0) stop = 1'b1;
                    else if (mseq[mwn-1] > eff) mwn--;
                    else stop = 1'b1;
                end
            end
            mtgt = eff;
            if (stop) begin
                while (mseq.size() > mwn) begin void'(mseq.pop_back()); void'(mcmp.pop_back()); end
                mwalk = 1'b0;
            end
        end
    endtask

    task automatic compare();
        int sz = mseq.size();
        chk("R2", "empty", empty, sz == 0);
        chk("R2", "full", full, sz == N);
        chk("R2", "free_cnt", free_cnt, N - sz);
        chk("R5", "alloc_idx", alloc_idx, (mhead + sz) % N);
        chk("R6", "sq_done", sq_done, !mwalk);
        chk("R3", "head_rdy", head_rdy, (sz > 0) && mcmp[0] && !(mwalk && mwn == 0));
        if (sz > 0) begin
            chk("R4", "head_seq", head_seq, mseq[0]);
            chk("R4", "head_pc", head_pc, pcof(mseq[0]));
            chk("R4", "head_npc", head_npc, pcof(mseq[0]) + 4);
            chk("R7", "tail_seq", tail_seq, mseq[sz-1]);
            chk("R7", "tail_pc", tail_pc, pcof(mseq[sz-1]));
        end
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        ins_en = 0; wb_en = 0; ret_en = 0; sq_en = 0;
    endtask

    task automatic set_ins(int s);
        ins_en = 1; ins_seq = SEQ_W'(s); ins_pc = PC_W'(pcof(s)); ins_npc = PC_W'(pcof(s) + 4);
    endtask

    task automatic ins(int s); set_ins(s); cyc(); endtask

    task automatic wb_pos(int p); wb_en = 1; wb_idx = IDX_W'((mhead + p) % N); cyc(); endtask

    task automatic walk_len();
        lowc = 0;
        while (!sq_done && lowc < 40) begin cyc(); lowc++; end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "empty", empty, 1);
        chk("R1", "full", full, 0);
        chk("R1", "free_cnt", free_cnt, N);
        chk("R1", "sq_done", sq_done, 1);
        chk("R1", "alloc_idx", alloc_idx, 0);

        for (int s = 1; s <= 8; s++) ins(s);
        chk("R2", "full after 8 inserts", full, 1);
        ins(99);
        chk("R2", "insert while full ignored", tail_seq, 8);

        ret_en = 1; cyc();
        chk("R4", "retire without ready ignored", head_seq, 1);
        wb_pos(0); wb_pos(1); wb_pos(2);
        chk("R3", "head ready after writeback", head_rdy, 1);
        for (int i = 0; i < 3; i++) begin ret_en = 1; cyc(); end
        chk("R4", "three retired", head_seq, 4);

        wb_pos(0);
        set_ins(9); ret_en = 1; cyc();
        chk("R5", "insert+retire keeps count", free_cnt, 3);
        chk("R5", "alloc wrapped", alloc_idx, 1);
        ins(10); ins(11);

        // squash to 8: three younger entries, SW=2 -> 2 walk cycles
        sq_en = 1; sq_seq = 8; set_ins(40); ret_en = 1; cyc();
        chk("R6", "done low after request", sq_done, 0);
        chk("R8", "insert in request cycle ignored", tail_seq, 11);
        set_ins(50); ret_en = 1;
        walk_len();
        chk("R6", "walk cycles m=3", lowc, 2);
        chk("R10", "target entry kept", tail_seq, 8);
        chk("R8", "no insert during walk", free_cnt, 4);
        chk("R8", "no retire during walk", head_seq, 5);

        for (int s = 20; s <= 23; s++) ins(s);
        sq_en = 1; sq_seq = 22; cyc();
        sq_en = 1; sq_seq = 8;
        walk_len();
        chk("R9", "older retarget walk cycles", lowc, 3);
        chk("R9", "older retarget tail", tail_seq, 8);

        ins(30); ins(31); ins(32);
        sq_en = 1; sq_seq = 30; cyc();
        sq_en = 1; sq_seq = 31;
        walk_len();
        chk("R9", "younger retarget ignored cycles", lowc, 2);
        chk("R9", "younger retarget ignored tail", tail_seq, 30);

        sq_en = 1; sq_seq = 0; cyc();
        walk_len();
        chk("R6", "walk cycles m=5", lowc, 3);
        chk("R10", "all squashed empty", empty, 1);

        sq_en = 1; sq_seq = 5; cyc();
        walk_len();
        chk("R6", "squash when empty", lowc, 1);

        ins(60); wb_pos(0);
        chk("R3", "ready after refill", head_rdy, 1);
        ret_en = 1; cyc();
        chk("R4", "retire after squash", empty, 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule